// File: doc/BRIEF.md
# Rectifier Startup Threshold and Gate Enable Sequencer

This block runs the power-up sequence of a synchronous rectifier controller. It takes four comparator flags: supply above its turn-on level, supply above its turn-off level, enable pin below the selection level, and enable pin above the enable level. It drives three outputs. The first switches the current sink on the enable pin. The second is a stored bit that picks the rectifier turn-off threshold. The third permits gate driving.

While the supply is low, the enable pin is loaded by its current sink and both gates are held off. When the supply crosses its turn-on level, the enable pin voltage is read once. That reading picks the deeper (−25 mV) or the shallower (−12 mV) turn-off threshold, and the pick stays fixed until the supply falls below its turn-off level. After turn-on the same pin acts as an enable input. Gates run only while the pin sits above the enable level. Every comparator flag is asynchronous and goes through a two-flop synchronizer before the sequencer uses it.

Top module: `sr_startup_seq`

## Requirements
- R1: During reset and on the first cycle after it, `sink_en` is 1, `gate_en` is 0 and `thr_sel` is 0.
- R2: Each comparator flag passes two synchronizer flops, followed by one state register. A raw flag change applied between clock edges therefore shows at the outputs on the third rising edge, and not earlier.
- R3: `sink_en` is 1 while the block is in lockout and 0 while it is running. Lockout is left only on the synchronized rising edge of `sup_on_raw` while `sup_off_raw` is also high.
- R4: On the turn-on edge, `thr_sel` is loaded with 0 (the −25 mV threshold) if `en_low_raw` is 1, and with 1 (the −12 mV threshold) if `en_low_raw` is 0.
- R5: While running, `thr_sel` does not change, whatever `en_low_raw` does.
- R6: After a return to lockout, `thr_sel` keeps its value until the next turn-on, whatever `en_low_raw` does.
- R7: While running, `gate_en` follows the synchronized `en_high_raw`, and `sink_en` stays 0 when the gates are disabled.
- R8: When the synchronized `sup_off_raw` goes low, the block returns to lockout and clears `gate_en` on the next edge. `sink_en` goes to 1 on that same edge.
- R9: A dip and recovery of `sup_on_raw` while `sup_off_raw` stays high neither reloads `thr_sel` nor leaves the running state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sup_on_raw | input | 1 | Supply above turn-on level (asynchronous) |
| sup_off_raw | input | 1 | Supply above turn-off level (asynchronous) |
| en_low_raw | input | 1 | Enable pin below threshold-selection level (asynchronous) |
| en_high_raw | input | 1 | Enable pin above gate-enable level (asynchronous) |
| sink_en | output | 1 | Turns on the enable-pin pull-down current sink |
| thr_sel | output | 1 | Turn-off threshold: 0 = −25 mV, 1 = −12 mV |
| gate_en | output | 1 | Gate drivers allowed to switch |

## Verification
The bench turns the block on twice, once with the enable pin low and once with it high at the turn-on instant. This shows that the threshold bit comes from the sample and is not a fixed value. It then moves the enable pin after turn-on and during lockout, which separates a frozen bit from one that tracks the pin. A supply-on dip with the off flag held high, and a supply-on rise with the off flag low, separate a true undervoltage cycle from a glitch. Single-edge steps around the first supply rise check the synchronizer latency exactly.

// File: rtl/sr_startup_pkg.sv
package sr_startup_pkg;

    typedef enum logic {
        SEQ_LOCKOUT = 1'b0,
        SEQ_RUN     = 1'b1
    } seq_state_e;

    typedef enum logic {
        THR_DEEP    = 1'b0,
        THR_SHALLOW = 1'b1
    } thr_sel_e;

    typedef struct packed {
        logic en_high;
        logic en_low;
        logic sup_off;
        logic sup_on;
    } cmp_flags_t;

    localparam int unsigned FLAG_BITS = $bits(cmp_flags_t);

    function automatic thr_sel_e pick_threshold(input logic en_below);
        return en_below ? THR_DEEP : THR_SHALLOW;
    endfunction

endpackage

// File: rtl/sr_flag_sync.sv
module sr_flag_sync #(
    parameter int unsigned WIDTH  = 4,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    localparam int unsigned LAST = STAGES - 1;

    logic [STAGES-1:0][WIDTH-1:0] pipe;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) pipe[0] <= '0;
                    else     pipe[0] <= din;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) pipe[s] <= '0;
                    else     pipe[s] <= pipe[s-1];
                end
            end
        end
    endgenerate

    assign dout = pipe[LAST];
endmodule

// File: rtl/sr_seq_fsm.sv
module sr_seq_fsm
    import sr_startup_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       sup_on_s,
    input  logic       sup_off_s,
    output seq_state_e state,
    output logic       take_sample,
    output logic       run_next
);
    seq_state_e nxt;
    logic       on_q;

    always_comb begin
        take_sample = (state == SEQ_LOCKOUT) && sup_on_s && !on_q && sup_off_s;
        nxt = state;
        case (state)
            SEQ_LOCKOUT: if (take_sample) nxt = SEQ_RUN;
            SEQ_RUN:     if (!sup_off_s)  nxt = SEQ_LOCKOUT;
            default:     nxt = SEQ_LOCKOUT;
        endcase
        run_next = (nxt == SEQ_RUN);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SEQ_LOCKOUT;
            on_q  <= 1'b0;
        end else begin
            state <= nxt;
            on_q  <= sup_on_s;
        end
    end

    // R8: a low off flag while running forces lockout on the next edge
    a_r8_drop_to_lockout: assert property (@(posedge clk) disable iff (rst)
        (state == SEQ_RUN && !sup_off_s) |=> (state == SEQ_LOCKOUT));

    // R3: entry into the running state needs the off flag high
    a_r3_entry_needs_off: assert property (@(posedge clk) disable iff (rst)
        (state == SEQ_RUN && $past(state) == SEQ_LOCKOUT) |-> $past(sup_off_s));
endmodule

// File: rtl/sr_thr_latch.sv
module sr_thr_latch
    import sr_startup_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       take_sample,
    input  logic       en_low_s,
    input  seq_state_e state,
    output thr_sel_e   thr_q
);
    always_ff @(posedge clk) begin
        if (rst)              thr_q <= THR_DEEP;
        else if (take_sample) thr_q <= pick_threshold(en_low_s);
    end

    // R5: the stored threshold is frozen while running
    a_r5_frozen_while_run: assert property (@(posedge clk) disable iff (rst)
        (state == SEQ_RUN && $past(state) == SEQ_RUN) |-> $stable(thr_q));

    // R4: the value loaded at turn-on reflects the sampled pin level
    a_r4_turn_on_value: assert property (@(posedge clk) disable iff (rst)
        (state == SEQ_RUN && $past(state) == SEQ_LOCKOUT)
            |-> (thr_q == pick_threshold($past(en_low_s))));
endmodule

// File: rtl/sr_gate_ctl.sv
module sr_gate_ctl (
    input  logic clk,
    input  logic rst,
    input  logic run_next,
    input  logic en_high_s,
    input  logic sup_off_s,
    output logic gate_q
);
    always_ff @(posedge clk) begin
        if (rst) gate_q <= 1'b0;
        else     gate_q <= run_next && en_high_s && sup_off_s;
    end
endmodule

// File: rtl/sr_startup_seq.sv
module sr_startup_seq
    import sr_startup_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic sup_on_raw,
    input  logic sup_off_raw,
    input  logic en_low_raw,
    input  logic en_high_raw,
    output logic sink_en,
    output logic thr_sel,
    output logic gate_en
);
    cmp_flags_t raw_flags;
    cmp_flags_t sync_flags;
    seq_state_e state;
    thr_sel_e   thr_q;
    logic       take_sample;
    logic       run_next;
    logic       gate_q;

    assign raw_flags.en_high = en_high_raw;
    assign raw_flags.en_low  = en_low_raw;
    assign raw_flags.sup_off = sup_off_raw;
    assign raw_flags.sup_on  = sup_on_raw;

    sr_flag_sync #(
        .WIDTH (FLAG_BITS),
        .STAGES(SYNC_STAGES)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .din (raw_flags),
        .dout(sync_flags)
    );

    sr_seq_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .sup_on_s   (sync_flags.sup_on),
        .sup_off_s  (sync_flags.sup_off),
        .state      (state),
        .take_sample(take_sample),
        .run_next   (run_next)
    );

    sr_thr_latch u_thr (
        .clk        (clk),
        .rst        (rst),
        .take_sample(take_sample),
        .en_low_s   (sync_flags.en_low),
        .state      (state),
        .thr_q      (thr_q)
    );

    sr_gate_ctl u_gate (
        .clk      (clk),
        .rst      (rst),
        .run_next (run_next),
        .en_high_s(sync_flags.en_high),
        .sup_off_s(sync_flags.sup_off),
        .gate_q   (gate_q)
    );

    assign sink_en = (state == SEQ_LOCKOUT);
    assign thr_sel = thr_q;
    assign gate_en = gate_q;

    // R7: gates are never enabled outside the running state
    a_r7_gate_needs_run: assert property (@(posedge clk) disable iff (rst)
        gate_en |-> (state == SEQ_RUN));

    // R1: reset leaves the sink on and the gates off
    a_r1_reset_state: assert property (@(posedge clk)
        $past(rst) |-> (sink_en && !gate_en && !thr_sel));
endmodule

// File: tb/sr_startup_seq_test.sv
module sr_startup_seq_test;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sup_on = 1'b0, sup_off = 1'b0, en_low = 1'b0, en_high = 1'b0;
    logic sink_en, thr_sel, gate_en;

    always #4 clk = ~clk;

    sr_startup_seq uut (
        .clk        (clk),
        .rst        (rst),
        .sup_on_raw (sup_on),
        .sup_off_raw(sup_off),
        .en_low_raw (en_low),
        .en_high_raw(en_high),
        .sink_en    (sink_en),
        .thr_sel    (thr_sel),
        .gate_en    (gate_en)
    );

    typedef struct {
        logic  sink;
        logic  thr;
        logic  gate;
        string tag;
    } exp_t;

    exp_t exp_q[$];
    int   n_checks = 0;
    int   n_fail   = 0;
    bit   done     = 1'b0;

    task automatic step(input int edges, input logic s, input logic t,
                        input logic g, input string tag);
        exp_t e;
        repeat (edges) @(posedge clk);
        e.sink = s; e.thr = t; e.gate = g; e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic drive(input logic on, input logic off,
                         input logic lo, input logic hi);
        @(negedge clk);
        sup_on = on; sup_off = off; en_low = lo; en_high = hi;
    endtask

    // monitor: compares each expectation at the following falling edge
    initial begin
        forever begin
            @(negedge clk);
            while (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                n_checks++;
                if ({sink_en, thr_sel, gate_en} !== {e.sink, e.thr, e.gate}) begin
                    n_fail++;
                    $display("FAIL %s: sink/thr/gate actual %b%b%b expected %b%b%b",
                             e.tag, sink_en, thr_sel, gate_en, e.sink, e.thr, e.gate);
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: run did not complete");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        step(0, 1'b1, 1'b0, 1'b0, "R1 in reset");
        @(negedge clk); rst = 1'b0;
        step(1, 1'b1, 1'b0, 1'b0, "R1 after reset");

        // supply above off level only: still locked out
        drive(1'b0, 1'b1, 1'b1, 1'b0);
        step(4, 1'b1, 1'b0, 1'b0, "R3 no turn-on without on flag");

        // turn-on with enable pin low: deep threshold, exact latency
        drive(1'b1, 1'b1, 1'b1, 1'b0);
        step(2, 1'b1, 1'b0, 1'b0, "R2 not before third edge");
        step(1, 1'b0, 1'b0, 1'b0, "R2 R4 turn-on deep, gate idle R7");

        // pin rises: threshold frozen, gates enabled after three edges
        drive(1'b1, 1'b1, 1'b0, 1'b1);
        step(2, 1'b0, 1'b0, 1'b0, "R2 gate latency");
        step(1, 1'b0, 1'b0, 1'b1, "R5 R7 frozen and gate on");

        drive(1'b1, 1'b1, 1'b0, 1'b0);
        step(3, 1'b0, 1'b0, 1'b0, "R7 gate off by pin, sink stays off");
        drive(1'b1, 1'b1, 1'b0, 1'b1);
        step(3, 1'b0, 1'b0, 1'b1, "R7 gate back on");

        // on-flag dip with off flag high
        drive(1'b0, 1'b1, 1'b0, 1'b1);
        step(3, 1'b0, 1'b0, 1'b1, "R9 dip keeps running");
        drive(1'b1, 1'b1, 1'b0, 1'b1);
        step(4, 1'b0, 1'b0, 1'b1, "R9 no resample on recovery");

        // undervoltage
        drive(1'b0, 1'b0, 1'b0, 1'b1);
        step(2, 1'b0, 1'b0, 1'b1, "R8 before shutdown edge");
        step(1, 1'b1, 1'b0, 1'b0, "R8 lockout and gate off");

        // second turn-on with pin high: shallow threshold
        drive(1'b0, 1'b1, 1'b0, 1'b1);
        step(3, 1'b1, 1'b0, 1'b0, "R3 still locked out");
        drive(1'b1, 1'b1, 1'b0, 1'b1);
        step(3, 1'b0, 1'b1, 1'b1, "R4 turn-on shallow");
        drive(1'b1, 1'b1, 1'b1, 1'b1);
        step(3, 1'b0, 1'b1, 1'b1, "R5 pin low ignored while running");

        // lockout holds the stored value
        drive(1'b0, 1'b0, 1'b1, 1'b1);
        step(3, 1'b1, 1'b1, 1'b0, "R6 held after shutdown");
        drive(1'b0, 1'b0, 1'b0, 1'b1);
        step(3, 1'b1, 1'b1, 1'b0, "R6 pin moves in lockout");
        drive(1'b0, 1'b0, 1'b1, 1'b1);
        step(3, 1'b1, 1'b1, 1'b0, "R6 pin moves again");

        // on flag rising while off flag low is not a turn-on
        drive(1'b1, 1'b0, 1'b1, 1'b1);
        step(4, 1'b1, 1'b1, 1'b0, "R3 on without off flag");

        // proper turn-on with pin low again
        drive(1'b0, 1'b1, 1'b1, 1'b1);
        step(3, 1'b1, 1'b1, 1'b0, "R3 waiting for on edge");
        drive(1'b1, 1'b1, 1'b1, 1'b1);
        step(3, 1'b0, 1'b0, 1'b1, "R4 resample deep");

        // reset while running
        @(negedge clk); rst = 1'b1;
        step(1, 1'b1, 1'b0, 1'b0, "R1 reset while running");
        @(negedge clk); rst = 1'b0;

        repeat (3) @(posedge clk);
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule